// File: doc/BRIEF.md
# Compare Timer with Single Software-Compare Channel

This block is a 32-bit up-counter timer that software drives through a simple single-cycle register bus. A control register turns counting on and sets a power-of-two prescaler. The counter wraps to zero after it reaches a programmable modulo value, and the wrap sets an overflow flag. One compare channel, when placed in software-compare mode, sets a channel flag on the prescaled tick in which the live count equals its compare value. This supports one-shot events: software reads the count, adds a delay and writes the sum as the compare value.

Both flags are cleared by writing one to them. The channel flag can be seen and cleared in two places: the channel control register and the global status register. A single level interrupt output combines each flag with its own enable. The bus has no wait states. A write takes effect at the clock edge on which it is presented. Read data is combinational from the address.

Top module: `cmp_timer`

## Requirements
- R1: After reset, every register reads zero except the modulo register (offset 0x18), which reads 0xFFFFFFFF. Reads of unmapped offsets return zero, and the interrupt output is low.
- R2: When the clock-mode field at control register (0x10) bits [4:3] is 01, the counter (0x14) advances by one on every 2^N clocks, where N is bits [2:0]. The divider restarts from zero each time counting is switched on, so after k clocks from the enabling edge the count is k>>N.
- R3: When the clock-mode field is 00, 10 or 11, the counter holds its value.
- R4: A write of any value to the counter offset sets the count to zero.
- R5: On a tick when the count equals the modulo value (0x18), the counter goes to zero and the overflow flag at control bit 7 sets.
- R6: When the channel mode field at channel control (0x20) bits [5:2] is 4, the channel flag at bit 7 sets on the tick where the count equals the channel value (0x24). In any other mode the flag does not set.
- R7: The channel flag is mirrored at global status (0x1C) bit 0. Writing 1 to channel control bit 7 or to global status bit 0 clears it. Writing 1 to control bit 7 clears the overflow flag. Writing 0 to any of these bits leaves the flag unchanged.
- R8: When a flag-setting event and a write-one-to-clear fall in the same cycle, the flag ends up set.
- R9: The interrupt output equals (channel flag AND channel control bit 6) OR (overflow flag AND control bit 6).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (8) | Register byte offset |
| bus_wen | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for bus_addr, combinational |
| irq | output | 1 | Level interrupt request |

## Verification
A write presented in one cycle is in the registers after the next rising edge. Reads return data in the same cycle with no edge consumed. Once counting is enabled at edge E0, the k-th following edge leaves a count of k>>N. Each flag appears one edge after the tick that produced it. The bench therefore enables counting, waits a chosen number of edges, and then freezes the counter with a disabling write. It adds one edge to the tick count for that write, so the expected count, wrap and flag state follow from (k+1)>>N. All reads happen while the counter is frozen, half a period away from the edge. The directed set-against-clear cases place the clearing write so that it lands on exactly the edge of the match, and then on the edge after it.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned OFF_CTRL   = 32'h10;
  localparam int unsigned OFF_COUNT  = 32'h14;
  localparam int unsigned OFF_MODULO = 32'h18;
  localparam int unsigned OFF_GSTAT  = 32'h1C;
  localparam int unsigned OFF_CHCTRL = 32'h20;
  localparam int unsigned OFF_CHVAL  = 32'h24;

  localparam int PSC_FIELD_W = 3;
  localparam int CMODE_W     = 2;
  localparam int CHMODE_W    = 4;

  localparam logic [CMODE_W-1:0]  CMODE_COUNT  = 2'b01;
  localparam logic [CHMODE_W-1:0] CHMODE_SWCMP = 4'h4;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PSC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PSC_W-1:0] psc_sel,
  output logic             tick
);
  localparam int DIV_W = (1 << PSC_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  always_comb begin
    for (int i = 0; i < DIV_W; i++) begin
      mask[i] = (i < int'(psc_sel));
    end
  end

  assign tick = run && ((div_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else if (run) begin
      div_q <= div_q + 1'b1;
    end else begin
      div_q <= '0;
    end
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              clr,
  input  logic [DATA_W-1:0] modulo,
  output logic [DATA_W-1:0] count,
  output logic              wrap
);
  logic at_limit;

  assign at_limit = (count == modulo);
  assign wrap     = tick && at_limit && !clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (clr) begin
      count <= '0;
    end else if (tick) begin
      count <= at_limit ? '0 : count + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic [DATA_W-1:0]   count,
  input  logic                wr_ctrl,
  input  logic [7:2]          ctrl_wdata,
  input  logic                wr_gstat_clr,
  input  logic                wr_val,
  input  logic [DATA_W-1:0]   val_wdata,
  output logic                flag,
  output logic                ie,
  output logic [CHMODE_W-1:0] mode,
  output logic [DATA_W-1:0]   cmp_val
);
  logic match;
  logic clear;

  assign match = tick && (mode == CHMODE_SWCMP) && (count == cmp_val);
  assign clear = (wr_ctrl && ctrl_wdata[7]) || wr_gstat_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie   <= 1'b0;
      mode <= '0;
    end else if (wr_ctrl) begin
      ie   <= ctrl_wdata[6];
      mode <= ctrl_wdata[5:2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_val <= '0;
    end else if (wr_val) begin
      cmp_val <= val_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
    end else if (match) begin
      flag <= 1'b1;
    end else if (clear) begin
      flag <= 1'b0;
    end
  end
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import tmr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wen,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic sel_ctrl, sel_count, sel_mod, sel_gstat, sel_chctrl, sel_chval;
  logic wr_ctrl, wr_count, wr_mod, wr_gstat, wr_chctrl, wr_chval;

  logic [PSC_FIELD_W-1:0] psc_q;
  logic [CMODE_W-1:0]     cmode_q;
  logic                   toie_q;
  logic                   tof_q;
  logic [DATA_W-1:0]      modulo_q;

  logic                   tick;
  logic                   wrap;
  logic [DATA_W-1:0]      cnt_q;

  logic                   ch_flag;
  logic                   ch_ie;
  logic [CHMODE_W-1:0]    ch_mode;
  logic [DATA_W-1:0]      ch_val;

  assign sel_ctrl   = (bus_addr == ADDR_W'(OFF_CTRL));
  assign sel_count  = (bus_addr == ADDR_W'(OFF_COUNT));
  assign sel_mod    = (bus_addr == ADDR_W'(OFF_MODULO));
  assign sel_gstat  = (bus_addr == ADDR_W'(OFF_GSTAT));
  assign sel_chctrl = (bus_addr == ADDR_W'(OFF_CHCTRL));
  assign sel_chval  = (bus_addr == ADDR_W'(OFF_CHVAL));

  assign wr_ctrl   = bus_wen && sel_ctrl;
  assign wr_count  = bus_wen && sel_count;
  assign wr_mod    = bus_wen && sel_mod;
  assign wr_gstat  = bus_wen && sel_gstat;
  assign wr_chctrl = bus_wen && sel_chctrl;
  assign wr_chval  = bus_wen && sel_chval;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_q   <= '0;
      cmode_q <= '0;
      toie_q  <= 1'b0;
    end else if (wr_ctrl) begin
      psc_q   <= bus_wdata[2:0];
      cmode_q <= bus_wdata[4:3];
      toie_q  <= bus_wdata[6];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tof_q <= 1'b0;
    end else if (wrap) begin
      tof_q <= 1'b1;
    end else if (wr_ctrl && bus_wdata[7]) begin
      tof_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      modulo_q <= '1;
    end else if (wr_mod) begin
      modulo_q <= bus_wdata;
    end
  end

  tmr_prescaler #(.PSC_W(PSC_FIELD_W)) i_psc (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (cmode_q == CMODE_COUNT),
    .psc_sel (psc_q),
    .tick    (tick)
  );

  tmr_counter #(.DATA_W(DATA_W)) i_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .clr    (wr_count),
    .modulo (modulo_q),
    .count  (cnt_q),
    .wrap   (wrap)
  );

  tmr_channel #(.DATA_W(DATA_W)) i_ch0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (tick),
    .count        (cnt_q),
    .wr_ctrl      (wr_chctrl),
    .ctrl_wdata   (bus_wdata[7:2]),
    .wr_gstat_clr (wr_gstat && bus_wdata[0]),
    .wr_val       (wr_chval),
    .val_wdata    (bus_wdata),
    .flag         (ch_flag),
    .ie           (ch_ie),
    .mode         (ch_mode),
    .cmp_val      (ch_val)
  );

  always_comb begin
    bus_rdata = '0;
    unique case (1'b1)
      sel_ctrl:   bus_rdata[7:0] = {tof_q, toie_q, 1'b0, cmode_q, psc_q};
      sel_count:  bus_rdata = cnt_q;
      sel_mod:    bus_rdata = modulo_q;
      sel_gstat:  bus_rdata[0] = ch_flag;
      sel_chctrl: bus_rdata[7:0] = {ch_flag, ch_ie, ch_mode, 2'b00};
      sel_chval:  bus_rdata = ch_val;
      default:    bus_rdata = '0;
    endcase
  end

  assign irq = (ch_flag && ch_ie) || (tof_q && toie_q);
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
  import tmr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_wen,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic                tick,
  input logic [CMODE_W-1:0]  cmode,
  input logic [DATA_W-1:0]   cnt,
  input logic [DATA_W-1:0]   modulo,
  input logic                tof,
  input logic [CHMODE_W-1:0] ch_mode,
  input logic [DATA_W-1:0]   ch_val,
  input logic                ch_flag
);
  logic cnt_wr;
  assign cnt_wr = bus_wen && (bus_addr == ADDR_W'(OFF_COUNT));

  a_r4_cnt_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt == '0));

  a_r3_no_tick_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (cmode != CMODE_COUNT) |-> !tick);

  a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_wr) |=> $stable(cnt));

  a_r5_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (cnt == modulo) && !cnt_wr) |=> ((cnt == '0) && tof));

  a_r8_match_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (ch_mode == CHMODE_SWCMP) && (cnt == ch_val)) |=> ch_flag);

  a_r6_flag_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ch_flag) |-> $past(tick));
endmodule

bind cmp_timer tmr_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_wen  (bus_wen),
  .bus_addr (bus_addr),
  .tick     (tick),
  .cmode    (cmode_q),
  .cnt      (cnt_q),
  .modulo   (modulo_q),
  .tof      (tof_q),
  .ch_mode  (ch_mode),
  .ch_val   (ch_val),
  .ch_flag  (ch_flag)
);

// File: tb/test_cmp_timer.sv
`timescale 1ns/1ps
module test_cmp_timer;
  localparam logic [7:0] A_CTRL = 8'h10, A_CNT = 8'h14, A_MOD = 8'h18,
                         A_GST = 8'h1C, A_CHC = 8'h20, A_CHV = 8'h24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wen = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  cmp_timer i_cmp_timer (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a falling edge; the write lands on the next rising edge.
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
  endtask

  function automatic logic [31:0] exp_count(int t, int m);
    return 32'(t % (m + 1));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_CTRL, d); chk("R1 ctrl", d, 32'h0);
    rd(A_CNT, d);  chk("R1 count", d, 32'h0);
    rd(A_MOD, d);  chk("R1 modulo", d, 32'hFFFF_FFFF);
    rd(A_GST, d);  chk("R1 gstat", d, 32'h0);
    rd(A_CHC, d);  chk("R1 chctrl", d, 32'h0);
    rd(A_CHV, d);  chk("R1 chval", d, 32'h0);
    rd(8'h2C, d);  chk("R1 unmapped", d, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);

    // R3 other clock modes hold
    wr(A_CTRL, 32'h10);
    repeat (20) @(negedge clk);
    rd(A_CNT, d); chk("R3 mode10 holds", d, 32'h0);
    wr(A_CTRL, 32'h18);
    repeat (20) @(negedge clk);
    rd(A_CNT, d); chk("R3 mode11 holds", d, 32'h0);
    wr(A_CTRL, 32'h00);

    // R8 set wins: match at cnt 5 (cycle 5), clear lands on edge E6
    wr(A_CHC, 32'h90);
    wr(A_CHV, 32'd5);
    wr(A_CNT, 32'h0);
    wr(A_CTRL, 32'h08);
    repeat (5) @(negedge clk);
    wr(A_GST, 32'h1);
    wr(A_CTRL, 32'h00);
    rd(A_CNT, d); chk("R2 count after 7 edges", d, 32'd7);
    rd(A_CHC, d); chk("R8 set beats clear", d, 32'h10 | 32'h80);

    // R7 writing zero leaves flag; mirror; ctrl W1C
    wr(A_CHC, 32'h50);
    rd(A_CHC, d); chk("R7 zero write keeps flag", d, 32'hD0);
    rd(A_GST, d); chk("R7 gstat mirror", d, 32'h1);
    chk("R9 irq from channel", {31'b0, irq}, 32'h1);
    wr(A_GST, 32'h0);
    rd(A_GST, d); chk("R7 gstat zero write keeps", d, 32'h1);
    wr(A_CHC, 32'hD0);
    rd(A_CHC, d); chk("R7 chctrl W1C", d, 32'h50);
    chk("R9 irq drops", {31'b0, irq}, 32'h0);

    // R7 clear one edge after the match: flag gone
    wr(A_CHC, 32'h10);
    wr(A_CNT, 32'h0);
    wr(A_CTRL, 32'h08);
    repeat (6) @(negedge clk);
    wr(A_GST, 32'h1);
    wr(A_CTRL, 32'h00);
    rd(A_GST, d); chk("R7 gstat W1C while running", d, 32'h0);

    // R4 count write clears
    rd(A_CNT, d); chk("R4 precondition nonzero", 32'(d != 0), 32'h1);
    wr(A_CNT, 32'hDEAD_BEEF);
    rd(A_CNT, d); chk("R4 write clears count", d, 32'h0);

    // R5 overflow and its W1C
    wr(A_MOD, 32'd2);
    wr(A_CTRL, 32'h48);
    repeat (4) @(negedge clk);
    wr(A_CTRL, 32'h40);
    rd(A_CNT, d);  chk("R5 wrapped count", d, 32'd2);
    rd(A_CTRL, d); chk("R5 overflow flag", d, 32'hC0);
    chk("R9 irq from overflow", {31'b0, irq}, 32'h1);
    wr(A_CTRL, 32'h40);
    rd(A_CTRL, d); chk("R7 tof zero write keeps", d, 32'hC0);
    wr(A_CTRL, 32'hC0);
    rd(A_CTRL, d); chk("R7 tof W1C", d, 32'h40);

    // Random runs: R2 R5 R6 R9
    for (int it = 0; it < 40; it++) begin
      int m, n, v, k, t;
      bit chon, chie, toie;
      logic exp_tof, exp_flag;
      m = 3 + int'($urandom % 18);
      n = int'($urandom % 4);
      v = int'($urandom % (m + 1));
      k = int'($urandom % 150);
      chon = $urandom % 2; chie = $urandom % 2; toie = $urandom % 2;
      wr(A_CTRL, 32'h80);
      wr(A_CHC, 32'h80 | (32'(chie) << 6) | ((chon ? 32'h4 : 32'h1) << 2));
      wr(A_MOD, 32'(m));
      wr(A_CHV, 32'(v));
      wr(A_CNT, 32'h0);
      wr(A_CTRL, (32'(toie) << 6) | 32'h08 | 32'(n));
      repeat (k) @(negedge clk);
      wr(A_CTRL, (32'(toie) << 6) | 32'(n));
      t = (k + 1) >> n;
      exp_tof  = (t >= m + 1);
      exp_flag = chon && (t >= v + 1);
      rd(A_CNT, d);  chk("R2 R5 random count", d, exp_count(t, m));
      rd(A_CTRL, d); chk("R5 random ctrl", d, {24'b0, exp_tof, toie, 3'b000, 3'(n)});
      rd(A_GST, d);  chk("R6 random flag", d, {31'b0, exp_flag});
      chk("R9 random irq", {31'b0, irq},
          {31'b0, (exp_flag && chie) || (exp_tof && toie)});
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule